// File: doc/BRIEF.md
# Cable-ID Role Selection Controller

This block decides whether a dual-role USB controller operates as host or as device, and carries out software requests to take over the host role. The role comes from the cable identification pin. A low level means an A-type plug is inserted and the controller starts as host. A high level means a B-type plug is inserted and the controller starts as device. The pin is asynchronous, so it passes through a synchronizer and then a debounce counter before the role logic uses it. Software can replace the pin with an override value of its own. The override acts on the next clock edge and skips the debounce.

While the controller is a device, software may raise a host request. The block then records a pending negotiation. It performs the swap to host only on a cycle in which the bus is reported idle. A disconnect while the request is pending cancels it instead. The pending flag clears on its own when the request either completes or is cancelled. The block also presents the current connection speed, registered, next to the role for status reads.

Top module: `role_sel_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released (pin high, override off), the role is device (`role_host_o`=0), `nego_o`=0 and `speed_o`=0.
- R2: With the override off, an effective ID of 0 makes the role host (`role_host_o`=1) and an effective ID of 1 makes it device (`role_host_o`=0). The role changes one clock edge after the debounced ID changes.
- R3: A pin level that differs from the debounced level is adopted only after it has been seen on DB_CYCLES consecutive edges after the synchronizer. The role therefore changes on the DB_CYCLES+3rd edge after the pin moves. A pulse lasting fewer cycles has no effect on the role.
- R4: When `id_ovr_en_i`=1, `id_ovr_val_i` replaces the debounced pin as the effective ID, with no debounce. A change of the effective ID caused by the override updates the role on the next edge.
- R5: A `host_req_i` pulse sampled while the role is device sets `nego_o` on the next edge and leaves the role at device. On the first later edge with `bus_idle_i`=1, the role becomes host and `nego_o` clears.
- R6: A `host_req_i` pulse sampled while the role is host is ignored: `nego_o` stays 0 and the role stays host.
- R7: While `nego_o`=1, `disconnect_i`=1 cancels the request: `nego_o` clears and the role stays device. Disconnect takes priority over a simultaneous `bus_idle_i`.
- R8: A change of the effective ID while `nego_o`=1 is discarded. The role stays device until the bus goes idle, and the change does not take effect afterwards.
- R9: After a negotiated swap, the role stays host while the effective ID does not change. The next change of the effective ID again sets the role from the ID value.
- R10: `speed_o` equals the value of `link_speed_i` sampled on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| id_pin_i | input | 1 | Asynchronous cable ID pin (0 = A plug) |
| id_ovr_en_i | input | 1 | Software override enable for the ID |
| id_ovr_val_i | input | 1 | Override ID value |
| host_req_i | input | 1 | Single-cycle host request pulse from software |
| bus_idle_i | input | 1 | Bus currently idle |
| disconnect_i | input | 1 | Peer disconnect seen |
| link_speed_i | input | SPEED_W | Current connection speed code |
| role_host_o | output | 1 | 1 = host role, 0 = device role |
| nego_o | output | 1 | Host request pending (self-clearing) |
| speed_o | output | SPEED_W | Registered connection speed status |

## Verification
The role is driven from the pin at both levels and timed exactly at the debounce edge. This separates a correct counter from one that is one cycle long or short. A glitch shorter than the debounce window then shows whether the counter restarts when the level returns. The override is switched on, changed and switched off again, which shows it bypassing the debounce and only its edges moving the role.

Host requests are tried in four situations:
- with the bus busy and then idle, which separates waiting for idle from swapping at once;
- from the host role, which shows a request that should be dropped;
- with disconnect and idle raised together, which shows the cancel priority;
- with an ID change during the wait, which shows whether ID changes are discarded while a request is pending.

// File: rtl/role_sel_pkg.sv
package role_sel_pkg;
  typedef enum logic [1:0] {
    ST_DEV  = 2'd0,
    ST_HOST = 2'd1,
    ST_SWAP = 2'd2
  } role_st_e;
endpackage

// File: rtl/id_sync.sv
module id_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stg_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[i] <= RST_VAL;
          else         stg_q[i] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) stg_q[i] <= RST_VAL;
          else         stg_q[i] <= stg_q[i-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/id_debounce.sv
module id_debounce #(
  parameter int unsigned CYCLES  = 16,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int unsigned CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] CNT_LAST = CW'(CYCLES - 1);

  logic          stable_q;
  logic [CW-1:0] cnt_q;
  logic          differ;

  assign differ = (d_i != stable_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stable_q <= RST_VAL;
      cnt_q    <= '0;
    end else if (!differ) begin
      cnt_q <= '0;
    end else if (cnt_q == CNT_LAST) begin
      stable_q <= d_i;
      cnt_q    <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = stable_q;
endmodule

// File: rtl/role_fsm.sv
module role_fsm
  import role_sel_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eff_id_i,
  input  logic host_req_i,
  input  logic bus_idle_i,
  input  logic disconnect_i,
  output logic role_host_o,
  output logic nego_o
);
  role_st_e st_q, st_d;
  logic     eff_id_q;
  logic     id_chg;

  assign id_chg = (eff_id_i != eff_id_q);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_DEV: begin
        if (id_chg && !eff_id_i) st_d = ST_HOST;
        else if (host_req_i)     st_d = ST_SWAP;
      end
      ST_HOST: begin
        if (id_chg && eff_id_i) st_d = ST_DEV;
      end
      ST_SWAP: begin
        // cancel wins over idle
        if (disconnect_i)    st_d = ST_DEV;
        else if (bus_idle_i) st_d = ST_HOST;
      end
      default: st_d = ST_DEV;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_DEV;
      eff_id_q <= 1'b1;
    end else begin
      st_q     <= st_d;
      eff_id_q <= eff_id_i;  // changes during pending request are absorbed
    end
  end

  assign role_host_o = (st_q == ST_HOST);
  assign nego_o      = (st_q == ST_SWAP);
endmodule

// File: rtl/role_sel_ctrl.sv
module role_sel_ctrl #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DB_CYCLES   = 16,
  parameter int unsigned SPEED_W     = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               id_pin_i,
  input  logic               id_ovr_en_i,
  input  logic               id_ovr_val_i,
  input  logic               host_req_i,
  input  logic               bus_idle_i,
  input  logic               disconnect_i,
  input  logic [SPEED_W-1:0] link_speed_i,
  output logic               role_host_o,
  output logic               nego_o,
  output logic [SPEED_W-1:0] speed_o
);
  logic id_sync_w;
  logic id_db_w;
  logic eff_id;

  id_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (id_pin_i),
    .q_o   (id_sync_w)
  );

  id_debounce #(.CYCLES(DB_CYCLES), .RST_VAL(1'b1)) u_db (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (id_sync_w),
    .q_o   (id_db_w)
  );

  assign eff_id = id_ovr_en_i ? id_ovr_val_i : id_db_w;

  role_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .eff_id_i    (eff_id),
    .host_req_i  (host_req_i),
    .bus_idle_i  (bus_idle_i),
    .disconnect_i(disconnect_i),
    .role_host_o (role_host_o),
    .nego_o      (nego_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) speed_o <= '0;
    else         speed_o <= link_speed_i;
  end
endmodule

// File: rtl/role_sel_chk.sv
module role_sel_chk #(
  parameter int unsigned SPEED_W = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               host_req_i,
  input logic               bus_idle_i,
  input logic               disconnect_i,
  input logic [SPEED_W-1:0] link_speed_i,
  input logic               role_host_o,
  input logic               nego_o,
  input logic [SPEED_W-1:0] speed_o
);
  // R5
  nego_dev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nego_o |-> !role_host_o);

  // R5
  nego_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nego_o) |-> ($past(host_req_i) && !$past(role_host_o)));

  // R5
  swap_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(nego_o) && !$past(disconnect_i)) |-> (role_host_o && $past(bus_idle_i)));

  // R7
  cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(nego_o) && $past(disconnect_i)) |-> !role_host_o);

  // R6
  host_req_ign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (role_host_o && host_req_i) |=> !nego_o);

  // R10
  speed_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (speed_o == $past(link_speed_i)));
endmodule

bind role_sel_ctrl role_sel_chk #(.SPEED_W(SPEED_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .host_req_i  (host_req_i),
  .bus_idle_i  (bus_idle_i),
  .disconnect_i(disconnect_i),
  .link_speed_i(link_speed_i),
  .role_host_o (role_host_o),
  .nego_o      (nego_o),
  .speed_o     (speed_o)
);

// File: tb/tb_role_sel_ctrl.sv
module tb_role_sel_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  DB = 8;
  localparam int  SW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          id_pin = 1'b1;
  logic          ovr_en = 1'b0;
  logic          ovr_val = 1'b1;
  logic          host_req = 1'b0;
  logic          bus_idle = 1'b0;
  logic          disc = 1'b0;
  logic [SW-1:0] lspeed = '0;
  logic          role_host;
  logic          nego;
  logic [SW-1:0] speed;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  role_sel_ctrl #(.SYNC_STAGES(2), .DB_CYCLES(DB), .SPEED_W(SW)) dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .id_pin_i    (id_pin),
    .id_ovr_en_i (ovr_en),
    .id_ovr_val_i(ovr_val),
    .host_req_i  (host_req),
    .bus_idle_i  (bus_idle),
    .disconnect_i(disc),
    .link_speed_i(lspeed),
    .role_host_o (role_host),
    .nego_o      (nego),
    .speed_o     (speed)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    cyc(2);
    chk("R1 role", role_host, 0);
    chk("R1 nego", nego, 0);
    chk("R1 speed", speed, 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R1 role after release", role_host, 0);
    chk("R1 nego after release", nego, 0);
  endtask

  task automatic t_pin_debounce();
    id_pin = 1'b0;
    cyc(DB + 2);
    chk("R3 role before debounce end", role_host, 0);
    cyc(1);
    chk("R3 R2 role host at debounce edge", role_host, 1);
    // glitch shorter than the window
    id_pin = 1'b1;
    cyc(DB - 1);
    id_pin = 1'b0;
    cyc(3 * DB);
    chk("R3 glitch ignored", role_host, 1);
    id_pin = 1'b1;
    cyc(DB + 4);
    chk("R2 pin high gives device", role_host, 0);
  endtask

  task automatic t_override();
    ovr_val = 1'b0; ovr_en = 1'b1;
    cyc(1);
    chk("R4 override low gives host", role_host, 1);
    ovr_val = 1'b1;
    cyc(1);
    chk("R4 override high gives device", role_host, 0);
    ovr_en = 1'b0;
    cyc(2);
    chk("R4 override off same level", role_host, 0);
    ovr_val = 1'b0; ovr_en = 1'b1;
    cyc(1);
    chk("R4 override again host", role_host, 1);
    ovr_en = 1'b0;
    cyc(1);
    chk("R4 release to pin high", role_host, 0);
  endtask

  task automatic t_negotiate();
    host_req = 1'b1;
    cyc(1);
    host_req = 1'b0;
    chk("R5 nego set", nego, 1);
    chk("R5 still device", role_host, 0);
    cyc(4);
    chk("R5 waits for idle", nego, 1);
    chk("R5 waits role", role_host, 0);
    bus_idle = 1'b1;
    cyc(1);
    bus_idle = 1'b0;
    chk("R5 swap to host", role_host, 1);
    chk("R5 nego cleared", nego, 0);
    cyc(5);
    chk("R9 host held", role_host, 1);
    host_req = 1'b1;
    cyc(1);
    host_req = 1'b0;
    chk("R6 nego stays low in host", nego, 0);
    chk("R6 role stays host", role_host, 1);
    ovr_val = 1'b0; ovr_en = 1'b1;
    cyc(1);
    chk("R9 id to low keeps host", role_host, 1);
    ovr_val = 1'b1;
    cyc(1);
    chk("R9 id change applies", role_host, 0);
    ovr_en = 1'b0;
    cyc(1);
  endtask

  task automatic t_cancel();
    host_req = 1'b1;
    cyc(1);
    host_req = 1'b0;
    chk("R7 pending", nego, 1);
    disc = 1'b1; bus_idle = 1'b1;
    cyc(1);
    disc = 1'b0; bus_idle = 1'b0;
    chk("R7 nego cancelled", nego, 0);
    chk("R7 stays device", role_host, 0);
  endtask

  task automatic t_id_during_nego();
    host_req = 1'b1;
    cyc(1);
    host_req = 1'b0;
    ovr_val = 1'b0; ovr_en = 1'b1;
    cyc(2);
    chk("R8 id change ignored role", role_host, 0);
    chk("R8 still pending", nego, 1);
    bus_idle = 1'b1;
    cyc(1);
    bus_idle = 1'b0;
    chk("R8 swap at idle", role_host, 1);
    chk("R8 nego clear", nego, 0);
    ovr_val = 1'b1;
    cyc(1);
    chk("R8 later change applies", role_host, 0);
    ovr_en = 1'b0;
    cyc(1);
  endtask

  task automatic t_speed();
    lspeed = 2'd2;
    cyc(1);
    chk("R10 speed 2", speed, 2);
    lspeed = 2'd1;
    cyc(1);
    chk("R10 speed 1", speed, 1);
    lspeed = 2'd3;
    cyc(1);
    chk("R10 speed 3", speed, 3);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_pin_debounce();
    t_override();
    t_negotiate();
    t_cancel();
    t_id_during_nego();
    t_speed();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule